// File: doc/BRIEF.md
# Highest-Priority Pending LPI Scanner

This block tracks the most urgent pending, enabled message-signalled interrupt for one processor. Both tables it works from sit in external memory. The pending table holds one bit per interrupt ID. The configuration table holds one byte per interrupt ID. The block reaches both through a byte-wide request/response port, and it presents the winning ID and its effective priority on its result outputs.

Software or a neighbouring block starts a full rescan with `scan_start`. It flips single pending bits with `cmd_valid`/`cmd_set`/`cmd_id`. The block keeps its answer current without rescanning after every change:

- A newly set bit is compared against the current winner and nothing else.
- A cleared bit triggers a full rescan, but only when it was the current winner.

Table bases, the programmed ID-bit count and the priority interpretation mode are static inputs. The host issues a new command only while `busy` is low and treats the result as fresh when `done` pulses.

Top module: `pend_irq_picker`

## Requirements
- R1: A full scan reports the lowest effective priority among pending, enabled IDs in [8192, S), where S = 2^(min(id_bits,15)+1). Ties go to the lowest ID. If there is no candidate, or S ≤ 8192, the result is priority 0xFF with ID 0.
- R2: In a configuration byte, bit 0 is the enable and bits 7:2 are the priority field. An entry with bit 0 clear never becomes the result.
- R3: With `raw_prio` high, the effective priority is entry & 0xFC. With it low, the effective priority is ((entry & 0xFC) >> 1) | 0x80. A valid result therefore always has bit 0 clear.
- R4: A command reads the pending byte at pend_base + id/8 and looks at bit id%8. If that bit already holds the requested value, the command writes nothing and leaves the result unchanged.
- R5: Otherwise the command writes that byte back to the same address, with only bit id%8 changed.
- R6: When a command sets a bit, only that ID is compared. It replaces the result if it is enabled and either its priority is lower, or its priority is equal and its ID is lower than or equal to the current ID.
- R7: When a command clears a bit, a full rescan runs if and only if the cleared ID equals the current result ID. Otherwise the result is kept.
- R8: A command is dropped when `lpi_en` is low, when the ID is below 8192, or when the ID is S or higher. A dropped command makes no memory request and leaves the result unchanged.
- R9: A scan started while `lpi_en` is low sets the result to none (0xFF, ID 0) and makes no memory request.
- R10: Starts and commands are accepted only while `busy` is low, and `scan_start` wins over a command in the same cycle. `done` pulses for one cycle as the last busy cycle. The result does not change while the block is idle.
- R11: At most one read is outstanding, and `mem_req` lasts one cycle. Read data is taken when `mem_rvalid` is high, which happens no earlier than the cycle after the request. Writes take no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lpi_en | input | 1 | Enables message-signalled interrupt handling |
| pend_base | input | ADDR_W | Byte address of the pending table |
| cfg_base | input | ADDR_W | Byte address of the configuration entry for ID 8192 |
| id_bits | input | 5 | Programmed ID-bit count (table holds 2^(id_bits+1) IDs) |
| raw_prio | input | 1 | 1: use the raw priority field; 0: halve it and set bit 7 |
| scan_start | input | 1 | Start a full rescan |
| cmd_valid | input | 1 | Single-ID set/clear command |
| cmd_set | input | 1 | 1 = set pending, 0 = clear pending |
| cmd_id | input | ID_W | Interrupt ID of the command |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| best_id | output | ID_W | Current winning ID |
| best_prio | output | 8 | Effective priority of the winner, 0xFF = none |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |

## Verification
The bench goes after equal-priority ties, both in a scan and in incremental sets. A design that compares with a strict inequality, or that prefers higher IDs, reports the wrong winner. It clears the current winner and clears a non-winner. A design that rescans on every clear, or never rescans, leaves a stale winner or causes extra traffic, and the memory request counter or the result exposes it. It sets a bit that is already set, which must cause no write. It sends IDs just below the range and just past the table end, and it sends commands and scans while disabled. In each case a leaking design issues requests or disturbs the result. A long random run of set/clear commands then exercises these paths together against a reference model.

// File: rtl/pir_pkg.sv
package pir_pkg;

    localparam int          IDB_W      = 5;
    localparam logic [7:0]  PRIO_NONE  = 8'hFF;
    localparam logic [7:0]  PRIO_FIELD = 8'hFC;
    localparam int          CFG_EN_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN_PRD,
        ST_SCAN_BITS,
        ST_SCAN_CRD,
        ST_CMD_PRD,
        ST_CMD_POST,
        ST_CMD_CRD,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] prio;
    } cfg_view_t;

    function automatic cfg_view_t decode_cfg(input logic [7:0] entry, input logic raw);
        cfg_view_t  v;
        logic [7:0] fld;
        fld    = entry & PRIO_FIELD;
        v.en   = entry[CFG_EN_BIT];
        v.prio = raw ? fld : ((fld >> 1) | 8'h80);
        return v;
    endfunction

endpackage

// File: rtl/pir_rank.sv
module pir_rank #(
    parameter int ID_W = 16
) (
    input  logic [7:0]      entry,
    input  logic            raw_mode,
    input  logic [ID_W-1:0] cand_id,
    input  logic [ID_W-1:0] cur_id,
    input  logic [7:0]      cur_prio,
    output logic [7:0]      cand_prio,
    output logic            wins
);
    import pir_pkg::*;

    cfg_view_t view;

    always_comb begin
        view      = decode_cfg(entry, raw_mode);
        cand_prio = view.prio;
        wins      = view.en &&
                    ((view.prio < cur_prio) ||
                     ((view.prio == cur_prio) && (cand_id <= cur_id)));
    end

endmodule

// File: rtl/pir_walk.sv
module pir_walk #(
    parameter int BYTE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [BYTE_W-1:0] init_idx,
    input  logic              load,
    input  logic [7:0]        load_bits,
    input  logic              clr,
    input  logic              advance,
    output logic [BYTE_W-1:0] byte_idx,
    output logic              has_bit,
    output logic [2:0]        bit_pos
);

    logic [7:0]        bits_q;
    logic [BYTE_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            bits_q <= '0;
        end else begin
            if (init) begin
                idx_q <= init_idx;
            end else if (advance) begin
                idx_q <= idx_q + 1'b1;
            end
            if (load) begin
                bits_q <= load_bits;
            end else if (clr) begin
                bits_q[bit_pos] <= 1'b0;
            end else if (init || advance) begin
                bits_q <= '0;
            end
        end
    end

    always_comb begin
        bit_pos = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (bits_q[i]) begin
                bit_pos = 3'(i);
            end
        end
    end

    assign has_bit  = |bits_q;
    assign byte_idx = idx_q;

endmodule

// File: rtl/pend_irq_picker.sv
module pend_irq_picker #(
    parameter int ID_W     = 16,
    parameter int ADDR_W   = 32,
    parameter int FIRST_ID = 8192
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lpi_en,
    input  logic [ADDR_W-1:0]       pend_base,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic [pir_pkg::IDB_W-1:0] id_bits,
    input  logic                    raw_prio,
    input  logic                    scan_start,
    input  logic                    cmd_valid,
    input  logic                    cmd_set,
    input  logic [ID_W-1:0]         cmd_id,
    output logic                    busy,
    output logic                    done,
    output logic [ID_W-1:0]         best_id,
    output logic [7:0]              best_prio,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    input  logic                    mem_rvalid,
    input  logic [7:0]              mem_rdata
);
    import pir_pkg::*;

    localparam int                BYTE_W     = ID_W - 3;
    localparam int                SZ_W       = ID_W + 1;
    localparam int                MAX_IDB    = ID_W - 1;
    localparam logic [BYTE_W-1:0] FIRST_BYTE = BYTE_W'(FIRST_ID / 8);

    state_e            state_q;
    logic [ID_W-1:0]   cmd_id_q;
    logic              cmd_set_q;
    logic [BYTE_W-1:0] last_q;
    logic [ID_W-1:0]   best_id_q;
    logic [7:0]        best_prio_q;
    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;

    // table geometry from the programmed ID-bit count
    logic [IDB_W-1:0]  eff_bits;
    logic [SZ_W-1:0]   tbl_size;
    logic              tbl_empty;
    logic [BYTE_W-1:0] last_byte;
    logic              in_range;

    assign eff_bits  = (id_bits > IDB_W'(MAX_IDB)) ? IDB_W'(MAX_IDB) : id_bits;
    assign tbl_size  = SZ_W'(1) << (eff_bits + IDB_W'(1));
    assign tbl_empty = tbl_size <= SZ_W'(FIRST_ID);
    assign last_byte = BYTE_W'((tbl_size >> 3) - SZ_W'(1));
    assign in_range  = ({1'b0, cmd_id} >= SZ_W'(FIRST_ID)) && ({1'b0, cmd_id} < tbl_size);

    // walker over the pending bytes
    logic              acc_scan;
    logic              acc_cmd;
    logic              rescan_hit;
    logic              w_init;
    logic              w_load;
    logic              w_clr;
    logic              w_adv;
    logic [BYTE_W-1:0] w_idx;
    logic              w_has;
    logic [2:0]        w_bit;
    logic              w_last;
    logic [ID_W-1:0]   walk_id;

    assign acc_scan   = (state_q == ST_IDLE) && scan_start;
    assign acc_cmd    = (state_q == ST_IDLE) && !scan_start && cmd_valid;
    assign rescan_hit = (state_q == ST_CMD_POST) && !cmd_set_q && (cmd_id_q == best_id_q);
    assign w_init     = (acc_scan && lpi_en && !tbl_empty) || rescan_hit;
    assign w_load     = (state_q == ST_SCAN_PRD) && mem_rvalid;
    assign w_clr      = (state_q == ST_SCAN_CRD) && mem_rvalid;
    assign w_last     = (w_idx == last_q);
    assign w_adv      = (state_q == ST_SCAN_BITS) && !w_has && !w_last;
    assign walk_id    = {w_idx, w_bit};

    pir_walk #(.BYTE_W(BYTE_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .init      (w_init),
        .init_idx  (FIRST_BYTE),
        .load      (w_load),
        .load_bits (mem_rdata),
        .clr       (w_clr),
        .advance   (w_adv),
        .byte_idx  (w_idx),
        .has_bit   (w_has),
        .bit_pos   (w_bit)
    );

    // candidate ranking
    logic [ID_W-1:0] cand_id;
    logic [7:0]      cand_prio;
    logic            cand_wins;

    assign cand_id = (state_q == ST_CMD_CRD) ? cmd_id_q : walk_id;

    pir_rank #(.ID_W(ID_W)) u_rank (
        .entry     (mem_rdata),
        .raw_mode  (raw_prio),
        .cand_id   (cand_id),
        .cur_id    (best_id_q),
        .cur_prio  (best_prio_q),
        .cand_prio (cand_prio),
        .wins      (cand_wins)
    );

    // updated pending byte for a command write-back
    logic [7:0] pend_upd;
    always_comb begin
        pend_upd                = mem_rdata;
        pend_upd[cmd_id_q[2:0]] = cmd_set_q;
    end

    logic [ADDR_W-1:0] cfg_addr_walk;
    logic [ADDR_W-1:0] cfg_addr_cmd;
    logic [ADDR_W-1:0] pend_addr_next;
    logic [ADDR_W-1:0] pend_addr_first;
    logic [ADDR_W-1:0] pend_addr_cmd;

    assign cfg_addr_walk   = cfg_base + ADDR_W'(walk_id - ID_W'(FIRST_ID));
    assign cfg_addr_cmd    = cfg_base + ADDR_W'(cmd_id_q - ID_W'(FIRST_ID));
    assign pend_addr_next  = pend_base + ADDR_W'(w_idx + 1'b1);
    assign pend_addr_first = pend_base + ADDR_W'(FIRST_BYTE);
    assign pend_addr_cmd   = pend_base + ADDR_W'(cmd_id >> 3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cmd_id_q    <= '0;
            cmd_set_q   <= 1'b0;
            last_q      <= '0;
            best_id_q   <= '0;
            best_prio_q <= PRIO_NONE;
            req_q       <= 1'b0;
            we_q        <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
        end else begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_scan) begin
                        last_q      <= last_byte;
                        best_id_q   <= '0;
                        best_prio_q <= PRIO_NONE;
                        if (!lpi_en || tbl_empty) begin
                            state_q <= ST_FIN;
                        end else begin
                            req_q   <= 1'b1;
                            addr_q  <= pend_addr_first;
                            state_q <= ST_SCAN_PRD;
                        end
                    end else if (acc_cmd) begin
                        cmd_id_q  <= cmd_id;
                        cmd_set_q <= cmd_set;
                        last_q    <= last_byte;
                        if (lpi_en && in_range) begin
                            req_q   <= 1'b1;
                            addr_q  <= pend_addr_cmd;
                            state_q <= ST_CMD_PRD;
                        end else begin
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_SCAN_PRD: begin
                    if (mem_rvalid) begin
                        state_q <= ST_SCAN_BITS;
                    end
                end
                ST_SCAN_BITS: begin
                    if (w_has) begin
                        req_q   <= 1'b1;
                        addr_q  <= cfg_addr_walk;
                        state_q <= ST_SCAN_CRD;
                    end else if (w_last) begin
                        state_q <= ST_FIN;
                    end else begin
                        req_q   <= 1'b1;
                        addr_q  <= pend_addr_next;
                        state_q <= ST_SCAN_PRD;
                    end
                end
                ST_SCAN_CRD: begin
                    if (mem_rvalid) begin
                        if (cand_wins) begin
                            best_id_q   <= walk_id;
                            best_prio_q <= cand_prio;
                        end
                        state_q <= ST_SCAN_BITS;
                    end
                end
                ST_CMD_PRD: begin
                    if (mem_rvalid) begin
                        if (mem_rdata[cmd_id_q[2:0]] == cmd_set_q) begin
                            state_q <= ST_FIN;
                        end else begin
                            req_q   <= 1'b1;
                            we_q    <= 1'b1;
                            wdata_q <= pend_upd;
                            state_q <= ST_CMD_POST;
                        end
                    end
                end
                ST_CMD_POST: begin
                    if (cmd_set_q) begin
                        req_q   <= 1'b1;
                        addr_q  <= cfg_addr_cmd;
                        state_q <= ST_CMD_CRD;
                    end else if (rescan_hit) begin
                        best_id_q   <= '0;
                        best_prio_q <= PRIO_NONE;
                        req_q       <= 1'b1;
                        addr_q      <= pend_addr_first;
                        state_q     <= ST_SCAN_PRD;
                    end else begin
                        state_q <= ST_FIN;
                    end
                end
                ST_CMD_CRD: begin
                    if (mem_rvalid) begin
                        if (cand_wins) begin
                            best_id_q   <= cmd_id_q;
                            best_prio_q <= cand_prio;
                        end
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign best_id   = best_id_q;
    assign best_prio = best_prio_q;
    assign mem_req   = req_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
    parameter int ID_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            lpi_en,
    input logic            scan_start,
    input logic            cmd_valid,
    input logic            busy,
    input logic            done,
    input logic [ID_W-1:0] best_id,
    input logic [7:0]      best_prio,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_rvalid
);

    assert_done_ends_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !scan_start && !cmd_valid) |=> ($stable(best_prio) && $stable(best_id)));

    assert_prio_shape_R3: assert property (@(posedge clk) disable iff (rst)
        (best_prio != 8'hFF) |-> !best_prio[0]);

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_rvalid));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && (scan_start || cmd_valid) && !lpi_en) |=> !mem_req);

    assert_req_in_op_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_read_gap_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);

endmodule

bind pend_irq_picker pir_checker #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lpi_en     (lpi_en),
    .scan_start (scan_start),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .best_id    (best_id),
    .best_prio  (best_prio),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid)
);

// File: tb/pend_irq_picker_test.sv
module pend_irq_picker_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          ID_W       = 16;
    localparam int          ADDR_W     = 32;
    localparam int          FIRST      = 8192;
    localparam logic [31:0] PB         = 32'h1000_0000;
    localparam logic [31:0] CB         = 32'h2000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b1;
    logic [4:0]        idb = 5'd13;
    logic              raw = 1'b0;
    logic              scan_start = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_set = 1'b0;
    logic [ID_W-1:0]   cmd_id = '0;
    logic              busy, done;
    logic [ID_W-1:0]   best_id;
    logic [7:0]        best_prio;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_rvalid = 1'b0;
    logic [7:0]        mem_rdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    pend_irq_picker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .FIRST_ID(FIRST)) uut (
        .clk(clk), .rst(rst), .lpi_en(en), .pend_base(PB), .cfg_base(CB),
        .id_bits(idb), .raw_prio(raw), .scan_start(scan_start),
        .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_id(cmd_id),
        .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [logic [31:0]];
    logic [7:0] shd [logic [31:0]];
    int n_chk = 0, n_fail = 0, wr_cnt = 0, req_cnt = 0;
    bit finished = 0;
    logic [15:0] model_id = '0;
    logic [7:0]  model_prio = 8'hFF;

    function automatic logic [7:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] shrd(input logic [31:0] a);
        return shd.exists(a) ? shd[a] : 8'h00;
    endfunction

    function automatic logic [7:0] prio_of(input logic [7:0] e);
        logic [7:0] f;
        f = e & 8'hFC;
        return raw ? f : ({1'b0, f[7:1]} | 8'h80);
    endfunction

    function automatic int tbl_size();
        int c;
        c = (idb > 5'd15) ? 15 : int'(idb);
        return 1 << (c + 1);
    endfunction

    // memory model: one-cycle request, read data 1-2 cycles later
    int          lat_left = 0;
    logic [7:0]  rd_hold = 8'h00;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            lat_left = 0;
        end else begin
            if (lat_left > 0) begin
                lat_left = lat_left - 1;
                if (lat_left == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= rd_hold;
                end
            end
            if (mem_req) begin
                req_cnt++;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    rd_hold  = rd(mem_addr);
                    lat_left = 1 + int'($urandom % 2);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_best(input string req);
        chk(best_id == model_id && best_prio == model_prio, req, "best {id,prio}",
            {8'h00, best_id, best_prio}, {8'h00, model_id, model_prio});
    endtask

    task automatic ref_scan(output logic [15:0] rid, output logic [7:0] rp);
        int sz;
        sz  = tbl_size();
        rid = '0;
        rp  = 8'hFF;
        for (int id = FIRST; id < sz; id++) begin
            logic [7:0] pb;
            pb = shrd(PB + 32'(id / 8));
            if (pb[id % 8]) begin
                logic [7:0] e;
                logic [7:0] p;
                e = rd(CB + 32'(id - FIRST));
                p = prio_of(e);
                if (e[0] && (p < rp || (p == rp && 16'(id) <= rid))) begin
                    rid = 16'(id);
                    rp  = p;
                end
            end
        end
    endtask

    task automatic set_pend(input int id, input bit v);
        logic [31:0] a;
        logic [7:0]  b;
        a = PB + 32'(id / 8);
        b = shrd(a);
        b[id % 8] = v;
        shd[a] = b;
        mem[a] = b;
    endtask

    task automatic set_cfg(input int id, input logic [7:0] e);
        mem[CB + 32'(id - FIRST)] = e;
    endtask

    task automatic rand_cfg();
        for (int id = FIRST; id < 2 * FIRST; id++) begin
            logic [7:0] e;
            e = 8'($urandom);
            e[0] = ($urandom % 4) != 0;
            set_cfg(id, e);
        end
    endtask

    task automatic run_scan();
        @(negedge clk);
        while (busy) @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        while (!done) @(negedge clk);
        if (!en) begin
            model_id   = '0;
            model_prio = 8'hFF;
        end else begin
            ref_scan(model_id, model_prio);
        end
    endtask

    task automatic run_cmd(input int id, input bit s);
        logic [31:0] a;
        logic [7:0]  b;
        logic [7:0]  e;
        logic [7:0]  p;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_set   = s;
        cmd_id    = 16'(id);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        if (en && id >= FIRST && id < tbl_size()) begin
            a = PB + 32'(id / 8);
            b = shrd(a);
            if (b[id % 8] != s) begin
                b[id % 8] = s;
                shd[a] = b;
                if (s) begin
                    e = rd(CB + 32'(id - FIRST));
                    p = prio_of(e);
                    if (e[0] && (p < model_prio || (p == model_prio && 16'(id) <= model_id))) begin
                        model_id   = 16'(id);
                        model_prio = p;
                    end
                end else if (16'(id) == model_id) begin
                    ref_scan(model_id, model_prio);
                end
            end
        end
    endtask

    task automatic check_byte(input int id, input string req);
        logic [31:0] a;
        a = PB + 32'(id / 8);
        chk(rd(a) == shrd(a), req, "pending byte", {24'h0, rd(a)}, {24'h0, shrd(a)});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual busy=%0b expected done", busy);
            summary();
            $finish;
        end
    end

    initial begin
        int old_id, w0, r0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!busy && !done, "R10", "idle after reset", {30'h0, busy, done}, 32'h0);
        chk(best_prio == 8'hFF && best_id == '0, "R1", "reset result",
            {8'h0, best_id, best_prio}, 32'h0000_00FF);

        // full scan, shifted priority
        rand_cfg();
        for (int k = 0; k < 40; k++) set_pend(FIRST + int'($urandom % 8192), 1'b1);
        run_scan();
        check_best("R1");
        @(negedge clk);
        chk(!busy, "R10", "busy after done", {31'h0, busy}, 32'h0);

        // raw priority
        raw = 1'b1;
        run_scan();
        check_best("R3");
        raw = 1'b0;
        run_scan();
        check_best("R3");

        // disable current winner entry
        old_id = int'(model_id);
        if (model_prio != 8'hFF) set_cfg(old_id, rd(CB + 32'(old_id - FIRST)) & 8'hFE);
        run_scan();
        check_best("R2");
        chk(best_id != 16'(old_id) || best_prio == 8'hFF, "R2", "disabled winner gone",
            {16'h0, best_id}, 32'(old_id));

        // scan while disabled
        en = 1'b0;
        r0 = req_cnt;
        run_scan();
        chk(best_prio == 8'hFF && best_id == '0, "R9", "disabled scan result",
            {8'h0, best_id, best_prio}, 32'h0000_00FF);
        chk(req_cnt == r0, "R9", "disabled scan requests", 32'(req_cnt), 32'(r0));
        en = 1'b1;

        // table too small to hold any LPI
        idb = 5'd12;
        run_scan();
        chk(best_prio == 8'hFF, "R1", "empty table", {24'h0, best_prio}, 32'hFF);
        idb = 5'd13;

        // directed incremental cases
        mem.delete();
        shd.delete();
        set_cfg(8200, 8'h41);
        set_cfg(9000, 8'h41);
        set_cfg(9100, 8'h41);
        set_cfg(9500, 8'h41);
        set_cfg(16383, 8'h05);
        run_scan();
        chk(best_prio == 8'hFF, "R1", "no pending", {24'h0, best_prio}, 32'hFF);
        run_cmd(9100, 1'b1);
        check_best("R6");
        chk(best_prio == 8'hA0, "R3", "shifted prio", {24'h0, best_prio}, 32'hA0);
        check_byte(9100, "R5");
        run_cmd(9000, 1'b1);
        check_best("R6");
        chk(best_id == 16'd9000, "R6", "equal prio lower id", {16'h0, best_id}, 32'd9000);
        run_cmd(9500, 1'b1);
        chk(best_id == 16'd9000, "R6", "equal prio higher id", {16'h0, best_id}, 32'd9000);
        w0 = wr_cnt;
        run_cmd(9500, 1'b1);
        chk(wr_cnt == w0, "R4", "no write when unchanged", 32'(wr_cnt), 32'(w0));
        check_best("R4");
        r0 = req_cnt;
        run_cmd(9100, 1'b0);
        check_best("R7");
        check_byte(9100, "R5");
        chk(req_cnt == r0 + 2, "R7", "no rescan on non-winner clear", 32'(req_cnt), 32'(r0 + 2));
        run_cmd(9000, 1'b0);
        check_best("R7");
        chk(best_id == 16'd9500, "R7", "rescan after winner clear", {16'h0, best_id}, 32'd9500);
        r0 = req_cnt;
        run_cmd(100, 1'b1);
        chk(req_cnt == r0, "R8", "id below range", 32'(req_cnt), 32'(r0));
        run_cmd(16384, 1'b1);
        chk(req_cnt == r0, "R8", "id past table", 32'(req_cnt), 32'(r0));
        check_best("R8");
        run_cmd(16383, 1'b1);
        check_best("R8");
        chk(best_id == 16'd16383 && best_prio == 8'h82, "R8", "last id accepted",
            {8'h0, best_id, best_prio}, {8'h0, 16'd16383, 8'h82});
        en = 1'b0;
        r0 = req_cnt;
        run_cmd(16383, 1'b0);
        chk(req_cnt == r0, "R8", "disabled command", 32'(req_cnt), 32'(r0));
        en = 1'b1;
        check_best("R8");

        // scan wins over a command in the same cycle
        @(negedge clk);
        while (busy) @(negedge clk);
        scan_start = 1'b1;
        cmd_valid  = 1'b1;
        cmd_set    = 1'b1;
        cmd_id     = 16'd8200;
        @(negedge clk);
        scan_start = 1'b0;
        cmd_valid  = 1'b0;
        while (!done) @(negedge clk);
        ref_scan(model_id, model_prio);
        check_byte(8200, "R10");
        check_best("R10");

        // random set/clear traffic on a small pool of IDs
        mem.delete();
        shd.delete();
        rand_cfg();
        for (int k = 0; k < 30; k++) set_pend(FIRST + int'($urandom % 512), 1'b1);
        run_scan();
        check_best("R1");
        for (int k = 0; k < 80; k++) begin
            int id;
            id = FIRST + int'($urandom % 512);
            run_cmd(id, 1'(($urandom % 2)));
            check_best("R6 R7");
            check_byte(id, "R5");
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule